// File: doc/BRIEF.md
# Motor Speed Discriminator with Lock Detect

This block measures how fast a brushless motor turns by timing its tachometer signal. The tachometer edge arrives already synchronised to the system clock as a one-cycle pulse. A reference tick enable sets the time base. Each measured period is counted in reference ticks and compared with a target count. Two strap inputs choose the target. For each measurement the block produces three outputs:

- a direction level telling the speed loop to speed up or slow down;
- a pulse whose length in reference ticks equals the size of the error;
- an active-low in-lock indicator, shaped like an open-collector pull-down.

Tachometer periods alternate between measuring and reporting. A period is counted, and the following period carries the error pulse. The block therefore gives one update for every two tachometer periods. The lock window is one sixteenth of the target on either side, which is a shift and a compare. The period counter stops at twice the target, so a stalled rotor reads as slowest-possible instead of wrapping round.

Top module: `spd_disc_top`

## Requirements
- R1: The target count is 1024 when `sel_a_i` is 1. It is 256 when `sel_a_i` is 0 and `sel_b_i` is 1. It is 512 when both are 0.
- R2: The measured count is the number of cycles with `ref_tick_i` high, from the cycle after the edge that starts a measurement up to and including the cycle of the edge that ends it. Only every other period is measured, so one result follows every two tachometer periods.
- R3: `accel_o` is 1 when the measured count is above the target and 0 otherwise. It takes its new value in the cycle after the ending edge and holds it until the next result.
- R4: `err_win_o` rises in the cycle after the ending edge. It stays high for |measured − target| reference ticks and is low when that difference is 0. It is forced low by the next tachometer edge, and it is never high during a measuring period.
- R5: The measured count saturates at twice the target. A stalled rotor therefore reads as `accel_o` = 1 with a pulse exactly one target long.
- R6: A result is in window when |measured − target| ≤ target/16. A difference of exactly target/16 is in window, and one more tick is out of window.
- R7: `lock_no_o` is 1 after reset. It goes to 0 only after two consecutive in-window results, and it returns to 1 on any out-of-window result.
- R8: The target is captured at the edge that starts a measurement. A strap change during that measurement does not affect its result.
- R9: The first tachometer edge after reset only starts a measurement. No result, pulse or direction change appears before the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fg_edge_i | input | 1 | One-cycle pulse per tachometer period, synchronised |
| ref_tick_i | input | 1 | Reference time-base enable; counted ticks |
| sel_a_i | input | 1 | Target strap A (1 selects 1024) |
| sel_b_i | input | 1 | Target strap B (with A low: 1 selects 256, 0 selects 512) |
| accel_o | output | 1 | 1 = motor too slow, speed up; 0 = slow down |
| err_win_o | output | 1 | Error-magnitude pulse, length in reference ticks |
| lock_no_o | output | 1 | 0 = speed within lock window |

## Verification
The assertions assume that `fg_edge_i` is a single-cycle pulse and that straps change only between cycles. They also assume that an error pulse is either finished or deliberately cut short by the next edge. The bench drives edges as isolated one-cycle pulses with exact spacing, holds `ref_tick_i` high so that ticks equal cycles, and changes straps only at falling clock edges. Periods are chosen around each window boundary, above and below the target, and well past saturation. One scenario moves the straps in the middle of a measurement.

// File: rtl/spd_disc_pkg.sv
package spd_disc_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_MEAS = 2'd1,
    PH_EMIT = 2'd2
  } phase_e;

  function automatic int unsigned sat_lim(input int unsigned tgt);
    return tgt * 2;
  endfunction
endpackage

// File: rtl/spd_disc_tgt_sel.sv
module spd_disc_tgt_sel #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned TGT_A = 1024,
  parameter int unsigned TGT_B = 256,
  parameter int unsigned TGT_C = 512
) (
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  output logic [CNT_W-1:0] tgt_o
);
  always_comb begin
    if (sel_a_i)      tgt_o = CNT_W'(TGT_A);
    else if (sel_b_i) tgt_o = CNT_W'(TGT_B);
    else              tgt_o = CNT_W'(TGT_C);
  end

  initial begin
    assert_tgt_fits_R1: assert (spd_disc_pkg::sat_lim(TGT_A) < (1 << CNT_W) &&
                                spd_disc_pkg::sat_lim(TGT_B) < (1 << CNT_W) &&
                                spd_disc_pkg::sat_lim(TGT_C) < (1 << CNT_W));
  end
endmodule

// File: rtl/spd_disc_meas.sv
module spd_disc_meas
  import spd_disc_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fg_edge_i,
  input  logic             ref_tick_i,
  input  logic [CNT_W-1:0] tgt_i,
  output phase_e           phase_o,
  output logic             res_vld_o,
  output logic             start_o,
  output logic [CNT_W-1:0] meas_o,
  output logic [CNT_W-1:0] tgt_q_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W:0]   lim, cnt_inc;

  assign lim     = {tgt_q, 1'b0};
  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, ref_tick_i};
  // Saturating count including the tick of the current cycle
  assign meas_o  = (cnt_inc >= lim) ? lim[CNT_W-1:0] : cnt_inc[CNT_W-1:0];

  assign start_o   = fg_edge_i && (phase_q != PH_MEAS);
  assign res_vld_o = fg_edge_i && (phase_q == PH_MEAS);

  always_comb begin
    phase_d = phase_q;
    if (fg_edge_i) begin
      unique case (phase_q)
        PH_WAIT: phase_d = PH_MEAS;
        PH_MEAS: phase_d = PH_EMIT;
        default: phase_d = PH_MEAS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
      tgt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (start_o) begin
        cnt_q <= '0;
        tgt_q <= tgt_i;
      end else if (phase_q == PH_MEAS) begin
        cnt_q <= meas_o;
      end
    end
  end

  assign phase_o = phase_q;
  assign tgt_q_o = tgt_q;

  assert_cnt_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} <= lim));
  assert_alt_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |=> (phase_q == PH_EMIT));
  assert_tgt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MEAS && !fg_edge_i) |=> $stable(tgt_q));
endmodule

// File: rtl/spd_disc_judge.sv
module spd_disc_judge #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned LOCK_SHIFT = 4,
  parameter int unsigned LOCK_RUN   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_vld_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic [CNT_W-1:0] tgt_i,
  output logic [CNT_W-1:0] diff_o,
  output logic             accel_o,
  output logic             lock_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

  logic [CNT_W-1:0] diff_raw;
  logic             slow, in_win;
  logic [RUN_W-1:0] run_q;
  logic             accel_q;

  assign slow     = meas_i > tgt_i;
  assign diff_raw = slow ? (meas_i - tgt_i) : (tgt_i - meas_i);
  assign diff_o   = (diff_raw > tgt_i) ? tgt_i : diff_raw;
  assign in_win   = diff_raw <= (tgt_i >> LOCK_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accel_q <= 1'b0;
      run_q   <= '0;
    end else if (res_vld_i) begin
      accel_q <= slow;
      if (!in_win)                       run_q <= '0;
      else if (run_q != RUN_W'(LOCK_RUN)) run_q <= run_q + 1'b1;
    end
  end

  assign accel_o = accel_q;
  assign lock_o  = (run_q == RUN_W'(LOCK_RUN));

  assert_accel_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_i |=> $stable(accel_q));
  assert_lock_needs_win_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_i && !in_win) |=> !lock_o);
  assert_lock_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(res_vld_i && in_win));
endmodule

// File: rtl/spd_disc_pulse.sv
module spd_disc_pulse #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             clear_i,
  input  logic             tick_i,
  output logic             win_o
);
  logic [CNT_W-1:0] pw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pw_q <= '0;
    else if (clear_i)              pw_q <= '0;
    else if (load_i)               pw_q <= width_i;
    else if (tick_i && pw_q != '0) pw_q <= pw_q - 1'b1;
  end

  assign win_o = (pw_q != '0);

  assert_cut_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !win_o);
  assert_load_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (pw_q == $past(width_i)));
endmodule

// File: rtl/spd_disc_top.sv
module spd_disc_top
  import spd_disc_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned TGT_A      = 1024,
  parameter int unsigned TGT_B      = 256,
  parameter int unsigned TGT_C      = 512,
  parameter int unsigned LOCK_SHIFT = 4,
  parameter int unsigned LOCK_RUN   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fg_edge_i,
  input  logic ref_tick_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  output logic accel_o,
  output logic err_win_o,
  output logic lock_no_o
);
  logic [CNT_W-1:0] tgt_sel, tgt_q, meas, diff;
  logic             res_vld, start, lock;
  phase_e           phase;

  spd_disc_tgt_sel #(.CNT_W(CNT_W), .TGT_A(TGT_A), .TGT_B(TGT_B), .TGT_C(TGT_C)) u_sel (
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .tgt_o(tgt_sel));

  spd_disc_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .fg_edge_i(fg_edge_i), .ref_tick_i(ref_tick_i),
    .tgt_i(tgt_sel), .phase_o(phase), .res_vld_o(res_vld), .start_o(start),
    .meas_o(meas), .tgt_q_o(tgt_q));

  spd_disc_judge #(.CNT_W(CNT_W), .LOCK_SHIFT(LOCK_SHIFT), .LOCK_RUN(LOCK_RUN)) u_judge (
    .clk_i(clk_i), .rst_ni(rst_ni), .res_vld_i(res_vld), .meas_i(meas), .tgt_i(tgt_q),
    .diff_o(diff), .accel_o(accel_o), .lock_o(lock));

  spd_disc_pulse #(.CNT_W(CNT_W)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(res_vld), .width_i(diff),
    .clear_i(start), .tick_i(ref_tick_i), .win_o(err_win_o));

  assign lock_no_o = !lock;

  assert_no_win_in_meas_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_EMIT) |-> !err_win_o);
  assert_quiet_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WAIT) |-> (!accel_o && lock_no_o));
endmodule

// File: tb/spd_disc_tb_top.sv
module spd_disc_top_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic fg_edge_i = 1'b0, ref_tick_i = 1'b1, sel_a_i = 1'b1, sel_b_i = 1'b1;
  logic accel_o, err_win_o, lock_no_o;
  int n_chk = 0, n_fail = 0, run = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spd_disc_top dut_i (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_in(input int p);
    repeat (p - 1) @(negedge clk);
    fg_edge_i = 1'b1;
    @(negedge clk);
    fg_edge_i = 1'b0;
  endtask

  function automatic int tgt_of(input logic a, input logic b);
    return a ? 1024 : (b ? 256 : 512);
  endfunction

  // Called right after the ending edge: checks direction, pulse length, lock
  task automatic check_result(input int p, input int t, input string req);
    int m, d, w;
    bit inw;
    m = (p > 2 * t) ? 2 * t : p;
    d = (m > t) ? m - t : t - m;
    inw = (d <= t / 16);
    run = inw ? ((run < 2) ? run + 1 : 2) : 0;
    chk(accel_o == (m > t), {req, " R3 accel"}, accel_o, m > t);
    chk(lock_no_o == !(run == 2), {req, " R7 lock_no"}, lock_no_o, !(run == 2));
    w = 0;
    while (err_win_o && w < 3000) begin
      w++;
      @(negedge clk);
    end
    chk(w == d, {req, " R4 pulse width"}, w, d);
  endtask

  task automatic one_update(input int p, input string req);
    int t;
    t = tgt_of(sel_a_i, sel_b_i);
    edge_in(4);
    edge_in(p);
    check_result(p, t, req);
  endtask

  task automatic t_first_period;
    edge_in(4);
    repeat (60) @(negedge clk);
    chk(!err_win_o && !accel_o && lock_no_o, "R9 no result after first edge",
        {err_win_o, accel_o, lock_no_o}, 3'b001);
    edge_in(1100 - 60);
    check_result(1100 - 60 + 60, 1024, "R9/R2 first result");
  endtask

  task automatic t_window_1024;
    one_update(1024, "R1 R6 exact target");
    one_update(1060, "R6 inside window");
    one_update(1088, "R6 upper boundary in");
    one_update(1089, "R6 upper boundary out");
    one_update(960,  "R6 lower boundary in");
    one_update(959,  "R6 lower boundary out");
  endtask

  task automatic t_other_targets;
    sel_a_i = 1'b0; sel_b_i = 1'b0;
    one_update(512, "R1 target 512");
    one_update(480, "R1 R6 512 lower edge");
    sel_b_i = 1'b1;
    one_update(272, "R1 target 256 edge");
    one_update(273, "R1 target 256 out");
  endtask

  task automatic t_stall;
    sel_a_i = 1'b0; sel_b_i = 1'b1;
    one_update(2000, "R5 stalled saturates");
  endtask

  task automatic t_latch;
    sel_a_i = 1'b1;
    edge_in(4);
    repeat (100) @(negedge clk);
    sel_a_i = 1'b0; sel_b_i = 1'b1;
    edge_in(924);
    check_result(1024, 1024, "R8 target captured");
    sel_a_i = 1'b1;
  endtask

  task automatic t_truncate;
    edge_in(4);
    edge_in(256);
    run = 0;
    chk(accel_o == 1'b0, "R3 fast gives decelerate", accel_o, 0);
    repeat (10) @(negedge clk);
    chk(err_win_o == 1'b1, "R4 pulse still running", err_win_o, 1);
    edge_in(1);
    chk(err_win_o == 1'b0, "R4 next edge cuts pulse", err_win_o, 0);
    edge_in(1024);
    check_result(1024, 1024, "R2 after cut");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!accel_o && !err_win_o && lock_no_o, "R7 reset state",
        {accel_o, err_win_o, lock_no_o}, 3'b001);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_first_period();
    t_window_1024();
    t_other_targets();
    t_stall();
    t_latch();
    t_truncate();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule